// File: doc/BRIEF.md
# Keyboard Matrix Scanner with Key-Code Queue

This block walks a key matrix of up to eight rows by eight columns. A clock divider sets the pace. On each divider tick the block looks at exactly one key position, given by the current row and column. The row is driven out on four scan lines, and the column is read back from eight active-low return lines. Each key position has a small debounce counter. A key that stays closed for three visits in a row is turned into an 8-bit code and pushed into an eight-entry queue. A processor reads the queue through a show-ahead data port with a pop strobe. It watches the queue level, three sticky status flags and an interrupt request.

A small state machine controls which closures may enter the queue:

- `S_OPEN`: new keys are free to enter.
- `S_LOCKED`: in lockout policy, one key holds the board, and every other key is ignored.
- `S_ERROR`: in rollover with the error option, writes to the queue are stopped.

The transitions are:

- `S_OPEN -> S_LOCKED`: the first key is seen under lockout.
- `S_LOCKED -> S_OPEN`: a complete scan finds no closed key.
- `S_OPEN -> S_ERROR`: a scan ends with two or more keys still in debounce, under rollover with the error option on.
- `S_ERROR -> S_OPEN`: the clear-status strobe.

Top module: `kbd_scan_top`

## Requirements
- R1: After reset the queue is empty, `irq`, `ovr_flag`, `udr_flag` and `err_flag` are low, and the row counter is 0 (so `scan_out` = 4'b0000 in encoded scan).
- R2: The block visits one key position every P clock cycles, where P = `prescale`, and values below 2 are treated as 2. Each row lasts eight visits, so one row lasts 8·P cycles.
- R3: With `scan_decoded`=1, `scan_out` is active-high one-hot (bit k high for row k), and there are four rows per scan. With `scan_decoded`=0, `scan_out[2:0]` carries the binary row number, `scan_out[3]`=0, and there are eight rows per scan.
- R4: A key enters the queue on its third consecutive closed visit, that is, two full scans after it is first seen. A closure that is shorter than this is not entered. A held key is entered only once.
- R5: The key code is: bit 7 = `cntl_key`, bit 6 = `shift_key` (both sampled at acceptance), bits 5:3 = row, bits 2:0 = column. The column is the index of the `ret_n` bit that is low.
- R6: The queue holds 8 codes, and `rd_data` shows the oldest one. The `rd_en` strobe pops it. A push into a full queue is dropped and sets `ovr_flag`. A pop from an empty queue sets `udr_flag`. Both flags stay set until `clr_status`.
- R7: Lockout (`rollover_en`=0): the first key seen takes the board. Other keys are ignored until a complete scan sees no key closed.
- R8: Rollover (`rollover_en`=1): every key is debounced on its own. Keys enter the queue in the order in which the scan first found them.
- R9: With rollover and `special_err_en`=1, a scan that ends with two or more keys mid-debounce sets `err_flag`. While the flag is set nothing is pushed, but reads and `irq` keep working. `clr_status` clears the flag.
- R10: `irq` is high whenever the queue holds a code. It stays high across reads until the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prescale | input | 5 | Visit period in cycles (2 to 31) |
| scan_decoded | input | 1 | 1: one-hot scan lines; 0: binary row number |
| rollover_en | input | 1 | 1: rollover policy; 0: lockout policy |
| special_err_en | input | 1 | Enable the simultaneous-press error under rollover |
| ret_n | input | 8 | Return lines, low = key closed |
| shift_key | input | 1 | Shift state, stored in the code |
| cntl_key | input | 1 | Control state, stored in the code |
| rd_en | input | 1 | Pop strobe for the queue |
| clr_status | input | 1 | Clears overrun, underrun and error |
| scan_out | output | 4 | Scan lines |
| rd_data | output | 8 | Oldest queued key code |
| fifo_count | output | 4 | Number of queued codes |
| irq | output | 1 | Interrupt request |
| ovr_flag | output | 1 | Sticky overrun |
| udr_flag | output | 1 | Sticky underrun |
| err_flag | output | 1 | Simultaneous-press error |

## Verification
The bench builds the block with its default parameters: a 5-bit divider and an eight-entry queue. It runs mostly with `prescale`=2, where a full encoded scan takes 128 cycles and a decoded scan 64. At that speed, debounce windows of several scans and full lockout/release sequences fit into a few thousand cycles. The divider values 5 and 0 are used to check the per-row dwell and the lower clamp. With a queue depth of eight, nine keys closed together reach the overrun case in a single debounce window.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
    localparam int ROW_W      = 3;
    localparam int COL_W      = 3;
    localparam int NCOL       = 2 ** COL_W;
    localparam int SCAN_LINES = 4;
    localparam int CODE_W     = 8;

    typedef enum logic [1:0] {
        S_OPEN   = 2'd0,
        S_LOCKED = 2'd1,
        S_ERROR  = 2'd2
    } kstate_t;

    typedef struct packed {
        logic             cntl;
        logic             shift;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } keycode_t;
endpackage

// File: rtl/kbd_prescaler.sv
module kbd_prescaler #(
    parameter int PRE_W   = 5,
    parameter int MIN_DIV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] div_cfg,
    output logic             tick
);
    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] lim;

    always_comb begin
        if (div_cfg < PRE_W'(MIN_DIV)) lim = PRE_W'(MIN_DIV - 1);
        else                           lim = div_cfg - PRE_W'(1);
    end

    assign tick = (cnt_q >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + PRE_W'(1);
    end
endmodule

// File: rtl/kbd_scan_ctr.sv
module kbd_scan_ctr #(
    parameter int ROW_W = 3,
    parameter int COL_W = 3,
    parameter int LINES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             decoded,
    output logic [ROW_W-1:0] row_q,
    output logic [COL_W-1:0] col_q,
    output logic             last_slot,
    output logic [LINES-1:0] scan_out
);
    localparam int DEC_W = $clog2(LINES);
    localparam logic [ROW_W-1:0] ROW_MAX_ENC = ROW_W'(2 ** ROW_W - 1);
    localparam logic [ROW_W-1:0] ROW_MAX_DEC = ROW_W'(LINES - 1);
    localparam logic [COL_W-1:0] COL_MAX     = COL_W'(2 ** COL_W - 1);

    logic [ROW_W-1:0] row_lim;
    logic             col_last;
    logic             row_last;

    assign row_lim   = decoded ? ROW_MAX_DEC : ROW_MAX_ENC;
    assign col_last  = (col_q == COL_MAX);
    assign row_last  = (row_q >= row_lim);
    assign last_slot = col_last && row_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
        end else if (tick) begin
            if (col_last) begin
                col_q <= '0;
                row_q <= row_last ? '0 : row_q + ROW_W'(1);
            end else begin
                col_q <= col_q + COL_W'(1);
            end
        end
    end

    for (genvar g = 0; g < LINES; g++) begin : g_line
        if (g < ROW_W) begin : g_enc
            assign scan_out[g] = decoded ? (row_q[DEC_W-1:0] == DEC_W'(g)) : row_q[g];
        end else begin : g_pad
            assign scan_out[g] = decoded && (row_q[DEC_W-1:0] == DEC_W'(g));
        end
    end
endmodule

// File: rtl/kbd_fifo.sv
module kbd_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    input  logic             clr,
    output logic [W-1:0]     rd_data,
    output logic [CNT_W-1:0] count,
    output logic             ovr,
    output logic             udr
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             full, empty, do_pop, do_push;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign rd_data = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovr    <= 1'b0;
            udr    <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= nxt(wr_ptr);
            if (do_pop)  rd_ptr <= nxt(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
            if (push && full && !do_pop) ovr <= 1'b1;
            else if (clr)                ovr <= 1'b0;
            if (pop && empty)            udr <= 1'b1;
            else if (clr)                udr <= 1'b0;
        end
    end
endmodule

// File: rtl/kbd_scan_top.sv
module kbd_scan_top
    import kbd_pkg::*;
#(
    parameter int  PRE_W      = 5,
    parameter int  FIFO_DEPTH = 8,
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PRE_W-1:0]      prescale,
    input  logic                  scan_decoded,
    input  logic                  rollover_en,
    input  logic                  special_err_en,
    input  logic [NCOL-1:0]       ret_n,
    input  logic                  shift_key,
    input  logic                  cntl_key,
    input  logic                  rd_en,
    input  logic                  clr_status,
    output logic [SCAN_LINES-1:0] scan_out,
    output logic [CODE_W-1:0]     rd_data,
    output logic [CNT_W-1:0]      fifo_count,
    output logic                  irq,
    output logic                  ovr_flag,
    output logic                  udr_flag,
    output logic                  err_flag
);
    localparam int KEY_W = ROW_W + COL_W;
    localparam int NKEYS = 2 ** KEY_W;

    logic             tick, last_slot, end_scan;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic [KEY_W-1:0] key_idx, lock_key_q;
    kstate_t          state_q, state_d;

    logic [1:0] deb_q [NKEYS];
    logic [1:0] old_cnt, new_cnt;
    logic       pressed, lock_block, eff_press, accept, push;
    logic       busy_slot, any_q, any_now;
    logic [1:0] busy_q, busy_now;
    keycode_t   code;

    kbd_prescaler #(.PRE_W(PRE_W), .MIN_DIV(2)) u_pre (
        .clk(clk), .rst_n(rst_n), .div_cfg(prescale), .tick(tick)
    );

    kbd_scan_ctr #(.ROW_W(ROW_W), .COL_W(COL_W), .LINES(SCAN_LINES)) u_scan (
        .clk(clk), .rst_n(rst_n), .tick(tick), .decoded(scan_decoded),
        .row_q(row_q), .col_q(col_q), .last_slot(last_slot), .scan_out(scan_out)
    );

    // Per-slot debounce evaluation
    always_comb begin
        key_idx    = {row_q, col_q};
        pressed    = !ret_n[col_q];
        lock_block = (state_q == S_LOCKED) && (key_idx != lock_key_q);
        eff_press  = pressed && !lock_block;
        old_cnt    = deb_q[key_idx];
        if (!eff_press)           new_cnt = 2'd0;
        else if (old_cnt == 2'd3) new_cnt = 2'd3;
        else                      new_cnt = old_cnt + 2'd1;
        accept    = tick && eff_press && (old_cnt == 2'd2);
        busy_slot = eff_press && (new_cnt == 2'd1 || new_cnt == 2'd2);
        any_now   = any_q || pressed;
        if (busy_slot && busy_q != 2'd2) busy_now = busy_q + 2'd1;
        else                             busy_now = busy_q;
        end_scan  = tick && last_slot;
        code      = '{cntl: cntl_key, shift: shift_key, row: row_q, col: col_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NKEYS; i++) deb_q[i] <= 2'd0;
        end else if (tick) begin
            deb_q[key_idx] <= new_cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            any_q  <= 1'b0;
            busy_q <= 2'd0;
        end else if (end_scan) begin
            any_q  <= 1'b0;
            busy_q <= 2'd0;
        end else if (tick) begin
            any_q  <= any_now;
            busy_q <= busy_now;
        end
    end

    // Acceptance policy state machine: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_OPEN: begin
                if (!rollover_en && tick && eff_press && old_cnt == 2'd0)
                    state_d = S_LOCKED;
                else if (rollover_en && special_err_en && end_scan && busy_now == 2'd2)
                    state_d = S_ERROR;
            end
            S_LOCKED: if (end_scan && !any_now) state_d = S_OPEN;
            S_ERROR:  if (clr_status)           state_d = S_OPEN;
            default:  state_d = S_OPEN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= S_OPEN;
            lock_key_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_OPEN && state_d == S_LOCKED) lock_key_q <= key_idx;
        end
    end

    // Outputs
    always_comb begin
        push     = accept && (state_q != S_ERROR);
        err_flag = (state_q == S_ERROR);
        irq      = (fifo_count != '0);
    end

    kbd_fifo #(.W(CODE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(code), .pop(rd_en),
        .clr(clr_status), .rd_data(rd_data), .count(fifo_count),
        .ovr(ovr_flag), .udr(udr_flag)
    );
endmodule

// File: rtl/kbd_scan_chk.sv
module kbd_scan_chk #(
    parameter int CNT_W = 4,
    parameter int DEPTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scan_decoded,
    input logic [3:0]       scan_out,
    input logic [CNT_W-1:0] fifo_count,
    input logic             irq,
    input logic             rd_en,
    input logic             err_flag,
    input logic             ovr_flag,
    input logic             clr_status
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CNT_W'(DEPTH)); // R6

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_flag && !clr_status |=> ovr_flag); // R6

    AST_SCAN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        scan_decoded |-> $countones(scan_out) == 1); // R3

    AST_ENC_TOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_decoded |-> scan_out[3] == 1'b0); // R3

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !rd_en |=> irq); // R10

    AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag && !clr_status |=> fifo_count <= $past(fifo_count)); // R9
endmodule

bind kbd_scan_top kbd_scan_chk #(.CNT_W(CNT_W), .DEPTH(FIFO_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .scan_decoded(scan_decoded), .scan_out(scan_out),
    .fifo_count(fifo_count), .irq(irq), .rd_en(rd_en), .err_flag(err_flag),
    .ovr_flag(ovr_flag), .clr_status(clr_status)
);

// File: tb/tb_kbd_scan_top.sv
module tb_kbd_scan_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] prescale = 5'd2;
    logic       scan_decoded = 1'b0, rollover_en = 1'b0, special_err_en = 1'b0;
    logic [7:0] ret_n;
    logic       shift_key = 1'b0, cntl_key = 1'b0, rd_en = 1'b0, clr_status = 1'b0;
    logic [3:0] scan_out;
    logic [7:0] rd_data;
    logic [3:0] fifo_count;
    logic       irq, ovr_flag, udr_flag, err_flag;

    logic [63:0] key_down = '0;
    int n_checks = 0;
    int n_bad = 0;

    localparam int SCAN_ENC = 128;  // 64 slots x 2 cycles
    localparam int SCAN_DEC = 64;   // 32 slots x 2 cycles

    // {row[2:0], col[2:0], shift, cntl, expected code[7:0]}
    localparam logic [15:0] VEC [4] = '{16'h0000, 16'hAA6A, 16'hFDBF, 16'h7BDE};

    always #10 clk = ~clk;

    kbd_scan_top dut (
        .clk(clk), .rst_n(rst_n), .prescale(prescale), .scan_decoded(scan_decoded),
        .rollover_en(rollover_en), .special_err_en(special_err_en), .ret_n(ret_n),
        .shift_key(shift_key), .cntl_key(cntl_key), .rd_en(rd_en), .clr_status(clr_status),
        .scan_out(scan_out), .rd_data(rd_data), .fifo_count(fifo_count), .irq(irq),
        .ovr_flag(ovr_flag), .udr_flag(udr_flag), .err_flag(err_flag)
    );

    // Key matrix model
    always_comb begin
        int r;
        if (scan_decoded) r = scan_out[0] ? 0 : scan_out[1] ? 1 : scan_out[2] ? 2 : 3;
        else              r = int'(scan_out[2:0]);
        ret_n = '1;
        for (int c = 0; c < 8; c++) if (key_down[r*8 + c]) ret_n[c] = 1'b0;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_one(output logic [7:0] d);
        @(negedge clk);
        d = rd_data;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        clr_status = 1'b1;
        @(negedge clk);
        clr_status = 1'b0;
    endtask

    task automatic settle();
        logic [7:0] d;
        key_down = '0;
        cyc(3 * SCAN_ENC);
        while (fifo_count != 0) read_one(d);
        pulse_clr();
    endtask

    task automatic row_dwell(output int n);
        logic [3:0] prev;
        @(negedge clk);
        prev = scan_out;
        while (scan_out == prev) @(negedge clk);
        prev = scan_out;
        n = 0;
        while (scan_out == prev) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL WDOG: actual=timeout expected=finished");
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int n;
        logic [7:0] seen;
        bit ok;

        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(fifo_count == 0 && !irq, "R1 empty", fifo_count, 0);
        check({ovr_flag, udr_flag, err_flag} == 3'b000, "R1 flags", {ovr_flag, udr_flag, err_flag}, 0);
        check(scan_out == 4'b0000, "R1 row", scan_out, 0);

        // R3 encoded: eight rows, top line low
        seen = '0; ok = 1;
        for (int i = 0; i < 2 * SCAN_ENC; i++) begin
            @(negedge clk);
            seen[scan_out[2:0]] = 1'b1;
            if (scan_out[3]) ok = 0;
        end
        check(seen == 8'hFF && ok, "R3 encoded", seen, 8'hFF);

        // R3 decoded: one-hot over four lines
        scan_decoded = 1'b1;
        seen = '0; ok = 1;
        for (int i = 0; i < 2 * SCAN_DEC; i++) begin
            @(negedge clk);
            seen[3:0] = seen[3:0] | scan_out;
            if ($countones(scan_out) != 1) ok = 0;
        end
        check(seen == 8'h0F && ok, "R3 decoded", seen, 8'h0F);

        // R4/R5 decoded key: row 2 col 1 -> 0x11
        cyc(SCAN_DEC);
        key_down[2*8 + 1] = 1'b1;
        cyc(4 * SCAN_DEC);
        key_down = '0;
        check(fifo_count == 1, "R4 decoded entry", fifo_count, 1);
        read_one(d);
        check(d == 8'h11, "R5 decoded code", d, 8'h11);
        scan_decoded = 1'b0;
        settle();

        // R2 divider
        prescale = 5'd5;
        row_dwell(n);
        check(n == 40, "R2 div5", n, 40);
        prescale = 5'd0;
        row_dwell(n);
        check(n == 16, "R2 clamp", n, 16);
        prescale = 5'd2;
        row_dwell(n);
        check(n == 16, "R2 div2", n, 16);

        // Table walk: R5 code layout, R4 acceptance
        for (int v = 0; v < 4; v++) begin
            shift_key = VEC[v][9];
            cntl_key  = VEC[v][8];
            key_down[VEC[v][15:13]*8 + VEC[v][12:10]] = 1'b1;
            cyc(4 * SCAN_ENC);
            key_down = '0;
            check(fifo_count == 1, "R4 table entry", fifo_count, 1);
            read_one(d);
            check(d == VEC[v][7:0], "R5 table code", d, VEC[v][7:0]);
            settle();
        end
        shift_key = 1'b0;
        cntl_key  = 1'b0;

        // R4 short closure then held key
        key_down[3*8 + 2] = 1'b1;
        cyc(192);
        check(fifo_count == 0, "R4 too short", fifo_count, 0);
        cyc(256);
        check(fifo_count == 1, "R4 third visit", fifo_count, 1);
        cyc(4 * SCAN_ENC);
        check(fifo_count == 1, "R4 held once", fifo_count, 1);
        settle();

        // R7 lockout: A row1 col1 (0x09), B row4 col3 (0x23)
        key_down[1*8 + 1] = 1'b1;
        cyc(4 * SCAN_ENC);
        key_down[4*8 + 3] = 1'b1;
        cyc(4 * SCAN_ENC);
        check(fifo_count == 1, "R7 second ignored", fifo_count, 1);
        key_down[1*8 + 1] = 1'b0;
        cyc(4 * SCAN_ENC);
        check(fifo_count == 1, "R7 lock until all up", fifo_count, 1);
        key_down = '0;
        cyc(2 * SCAN_ENC);
        key_down[4*8 + 3] = 1'b1;
        cyc(4 * SCAN_ENC);
        check(fifo_count == 2, "R7 after release", fifo_count, 2);
        read_one(d);
        check(d == 8'h09, "R7 first code", d, 8'h09);
        read_one(d);
        check(d == 8'h23, "R7 second code", d, 8'h23);
        settle();

        // R8 rollover: held A then B, both entered
        rollover_en = 1'b1;
        key_down[1*8 + 1] = 1'b1;
        cyc(4 * SCAN_ENC);
        key_down[4*8 + 3] = 1'b1;
        cyc(4 * SCAN_ENC);
        check(fifo_count == 2, "R8 both", fifo_count, 2);
        read_one(d);
        check(d == 8'h09, "R8 first", d, 8'h09);
        read_one(d);
        check(d == 8'h23, "R8 second", d, 8'h23);
        settle();

        // R8 scan order: rows 2 and 5 pressed together during row 1
        @(negedge clk);
        while (scan_out != 4'd1) @(negedge clk);
        key_down[5*8 + 0] = 1'b1;
        key_down[2*8 + 0] = 1'b1;
        cyc(4 * SCAN_ENC);
        read_one(d);
        check(d == 8'h10, "R8 order first", d, 8'h10);
        read_one(d);
        check(d == 8'h28, "R8 order second", d, 8'h28);
        settle();

        // R9 special error
        special_err_en = 1'b1;
        key_down[6*8 + 4] = 1'b1;
        cyc(4 * SCAN_ENC);
        check(fifo_count == 1 && !err_flag, "R9 single ok", {err_flag, fifo_count}, 1);
        key_down = '0;
        cyc(2 * SCAN_ENC);
        key_down[1*8 + 2] = 1'b1;
        key_down[3*8 + 3] = 1'b1;
        cyc(4 * SCAN_ENC);
        check(err_flag == 1'b1, "R9 error set", err_flag, 1);
        check(fifo_count == 1 && irq, "R9 writes blocked irq kept", {irq, fifo_count}, 5'h11);
        read_one(d);
        check(d == 8'h34 && fifo_count == 0, "R9 read works", d, 8'h34);
        pulse_clr();
        check(err_flag == 1'b0, "R9 clear", err_flag, 0);
        special_err_en = 1'b0;
        settle();

        // R6 overrun, R10 irq, R6 underrun
        key_down = 64'h1FF;
        cyc(4 * SCAN_ENC);
        key_down = '0;
        check(fifo_count == 8, "R6 full", fifo_count, 8);
        check(ovr_flag == 1'b1, "R6 overrun", ovr_flag, 1);
        for (int i = 0; i < 7; i++) read_one(d);
        check(irq == 1'b1, "R10 irq held", irq, 1);
        read_one(d);
        check(irq == 1'b0 && fifo_count == 0, "R10 irq drops at empty", irq, 0);
        check(udr_flag == 1'b0, "R6 no underrun yet", udr_flag, 0);
        read_one(d);
        check(udr_flag == 1'b1, "R6 underrun", udr_flag, 1);
        pulse_clr();
        check(!ovr_flag && !udr_flag, "R6 flags clear", {ovr_flag, udr_flag}, 0);

        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule